// File: doc/BRIEF.md
# Software Interrupt Crossbar

This block carries software-raised interrupts between up to eight CPU ports. Any requester posts a send word that names an interrupt ID from 0 to 15 and a set of destination CPUs. The block records one pending flag per destination, per source CPU and per ID. Each CPU port then sees its most urgent deliverable interrupt as an acknowledge value. Reading it takes the interrupt, which moves it from pending to active. A completion write or a bitwise clear-active write later releases the active state.

A pulse on the read strobe performs an acknowledge read. The value shown in that cycle is the value returned. Pending state is kept per source. Two CPUs that raise the same ID towards one target therefore produce two separate deliveries, each carrying its own source number.

Top module: `sgi_xbar`

## Requirements
- R1: Send word layout: the ID sits in bits [3:0] and the destination list in bits [23:16]. A send whose bits [15:4] are not all zero names an out-of-range ID and is dropped without effect. With a mode field of 0 in bits [25:24], exactly the CPUs whose list bits are set receive the interrupt.
- R2: With mode field 1, every CPU except the requester (send_src_i) receives the interrupt.
- R3: With mode field 2, only the requester receives the interrupt. Mode field 3 targets no CPU.
- R4: The acknowledge value holds the ID in bits [9:0] and the source CPU in bits [12:10]. When nothing is deliverable it is 1023, with bits [12:10] zero.
- R5: Among deliverable interrupts, the lowest ID is presented first. On a tie in ID, the lowest source number is presented first.
- R6: An acknowledge read of a non-spurious value clears that pending flag and sets its active flag. Each send yields exactly one delivery per targeted CPU.
- R7: An ID/source pair that is active is not presented, even if it has been sent again.
- R8: A completion write clears the active flag of the pair it names, with ID in [9:0] and source in [12:10]. A write that names another source leaves the active pair untouched.
- R9: A clear-active write with bit i set clears the active flag of ID i for every source on that CPU.
- R10: Pending state is independent per source CPU, so the same ID from different sources is delivered once per source.
- R11: After reset every port reads 1023 and irq_o is low. irq_o[c] is high exactly when port c has a deliverable interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| send_valid_i | input | 1 | Send word strobe |
| send_src_i | input | 3 | CPU number of the requester |
| send_data_i | input | 26 | Send word: mode [25:24], list [23:16], ID [3:0] |
| ack_rd_i | input | NUM_CPU | Acknowledge read strobe, one per CPU |
| ack_value_o | output | NUM_CPU*13 | Acknowledge value per CPU: source [12:10], ID [9:0] |
| irq_o | output | NUM_CPU | Interrupt request per CPU |
| eoi_valid_i | input | NUM_CPU | Completion write strobe per CPU |
| eoi_data_i | input | NUM_CPU*13 | Completion value per CPU, same layout as the acknowledge value |
| clr_act_valid_i | input | NUM_CPU | Clear-active write strobe per CPU |
| clr_act_data_i | input | NUM_CPU*16 | Clear-active bit mask per CPU, one bit per ID |

## Verification
The bench checks each mode field against its exact target set. A decoder that swapped modes 1 and 2, or let the requester into its own broadcast, would deliver to the wrong ports. It checks ordering with two sources of the same ID and a higher ID queued on one port. A single flag per ID would lose a delivery, and a wrong scan order would show IDs or sources out of order. It also resends a pair that is still active and completes it first with the wrong source, then with the right one. A design that presented active pairs, or completed by ID alone, would show a value where 1023 is expected. Clear-active across two active sources of one ID, the dropped out-of-range ID and mode 3 cover the remaining paths.

// File: rtl/sgi_pkg.sv
package sgi_pkg;
  localparam int SRC_W     = 3;
  localparam int ACK_W     = 13;
  localparam int IDF_W     = 10;
  localparam int SEND_W    = 26;
  localparam int LIST_LSB  = 16;
  localparam int MODE_LSB  = 24;
  localparam logic [IDF_W-1:0] SPUR_ID = 10'd1023;

  typedef enum logic [1:0] {
    MODE_LIST   = 2'd0,
    MODE_OTHERS = 2'd1,
    MODE_SELF   = 2'd2,
    MODE_NONE   = 2'd3
  } send_mode_e;
endpackage

// File: rtl/sgi_send_decode.sv
module sgi_send_decode
  import sgi_pkg::*;
#(
  parameter int NUM_CPU = 8
) (
  input  logic               valid_i,
  input  logic [SRC_W-1:0]   src_i,
  input  send_mode_e         mode_i,
  input  logic [7:0]         list_i,
  output logic [NUM_CPU-1:0] tgt_o
);
  logic [NUM_CPU-1:0] self_oh;

  always_comb begin
    for (int c = 0; c < NUM_CPU; c++) self_oh[c] = (int'(src_i) == c);
  end

  always_comb begin
    tgt_o = '0;
    if (valid_i) begin
      unique case (mode_i)
        MODE_LIST:   tgt_o = list_i[NUM_CPU-1:0];
        MODE_OTHERS: tgt_o = ~self_oh;
        MODE_SELF:   tgt_o = self_oh;
        default:     tgt_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/sgi_pick.sv
module sgi_pick
  import sgi_pkg::*;
#(
  parameter int NUM_CPU = 8,
  parameter int NUM_SGI = 16,
  localparam int ID_W   = $clog2(NUM_SGI),
  localparam int N      = NUM_SGI * NUM_CPU
) (
  input  logic [N-1:0]     cand_i,
  output logic             found_o,
  output logic [ID_W-1:0]  id_o,
  output logic [SRC_W-1:0] src_o
);
  // flat index = id*NUM_CPU + src, so lowest index = lowest id, then lowest src
  always_comb begin
    found_o = 1'b0;
    id_o    = '0;
    src_o   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (cand_i[i]) begin
        found_o = 1'b1;
        id_o    = ID_W'(i / NUM_CPU);
        src_o   = SRC_W'(i % NUM_CPU);
      end
    end
  end
endmodule

// File: rtl/sgi_cpu_slot.sv
module sgi_cpu_slot
  import sgi_pkg::*;
#(
  parameter int NUM_CPU = 8,
  parameter int NUM_SGI = 16,
  localparam int ID_W   = $clog2(NUM_SGI),
  localparam int N      = NUM_SGI * NUM_CPU,
  localparam int IDX_W  = $clog2(N)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               set_en_i,
  input  logic [SRC_W-1:0]   set_src_i,
  input  logic [ID_W-1:0]    set_id_i,
  input  logic               ack_rd_i,
  output logic [ACK_W-1:0]   ack_value_o,
  output logic               irq_o,
  input  logic               eoi_en_i,
  input  logic [ACK_W-1:0]   eoi_data_i,
  input  logic               clr_en_i,
  input  logic [NUM_SGI-1:0] clr_data_i
);
  logic [N-1:0]       pend_q, pend_d, act_q, act_d;
  logic               found;
  logic [ID_W-1:0]    sel_id;
  logic [SRC_W-1:0]   sel_src;
  logic [IDX_W-1:0]   sel_idx, set_idx, eoi_idx;
  logic [IDF_W-1:0]   eoi_id_f;
  logic [SRC_W-1:0]   eoi_src_f;
  logic               eoi_ok, take;

  function automatic logic [IDX_W-1:0] flat(logic [ID_W-1:0] id, logic [SRC_W-1:0] src);
    return IDX_W'(int'(id) * NUM_CPU + int'(src));
  endfunction

  sgi_pick #(.NUM_CPU(NUM_CPU), .NUM_SGI(NUM_SGI)) u_pick (
    .cand_i (pend_q & ~act_q),
    .found_o(found),
    .id_o   (sel_id),
    .src_o  (sel_src)
  );

  assign sel_idx   = flat(sel_id, sel_src);
  assign set_idx   = flat(set_id_i, set_src_i);
  assign eoi_id_f  = eoi_data_i[IDF_W-1:0];
  assign eoi_src_f = eoi_data_i[ACK_W-1:IDF_W];
  assign eoi_ok    = eoi_en_i && (eoi_id_f < IDF_W'(NUM_SGI)) && (int'(eoi_src_f) < NUM_CPU);
  assign eoi_idx   = flat(eoi_id_f[ID_W-1:0], eoi_src_f);
  assign take      = ack_rd_i && found;

  always_comb begin
    pend_d = pend_q;
    if (take)     pend_d[sel_idx] = 1'b0;
    if (set_en_i) pend_d[set_idx] = 1'b1;
  end

  always_comb begin
    act_d = act_q;
    if (eoi_ok) act_d[eoi_idx] = 1'b0;
    if (clr_en_i) begin
      for (int i = 0; i < NUM_SGI; i++) begin
        if (clr_data_i[i]) begin
          for (int s = 0; s < NUM_CPU; s++) act_d[flat(ID_W'(i), SRC_W'(s))] = 1'b0;
        end
      end
    end
    if (take) act_d[sel_idx] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= '0;
      act_q  <= '0;
    end else begin
      pend_q <= pend_d;
      act_q  <= act_d;
    end
  end

  assign ack_value_o = found ? ((ACK_W'(sel_src) << IDF_W) | ACK_W'(sel_id)) : ACK_W'(SPUR_ID);
  assign irq_o       = found;

  AST_ACK_ACTIVATES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take |=> act_q[$past(sel_idx)]); // R6
  AST_ACK_DROPS_PEND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take && !(set_en_i && set_idx == sel_idx)) |=> !pend_q[$past(sel_idx)]); // R6
  AST_NO_ACTIVE_SHOWN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    found |-> !act_q[sel_idx]); // R7
  AST_SEND_PENDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_en_i |=> pend_q[$past(set_idx)]); // R10
endmodule

// File: rtl/sgi_xbar.sv
module sgi_xbar
  import sgi_pkg::*;
#(
  parameter int NUM_CPU = 8,
  parameter int NUM_SGI = 16,
  localparam int ID_W   = $clog2(NUM_SGI)
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       send_valid_i,
  input  logic [SRC_W-1:0]           send_src_i,
  input  logic [SEND_W-1:0]          send_data_i,
  input  logic [NUM_CPU-1:0]         ack_rd_i,
  output logic [NUM_CPU*ACK_W-1:0]   ack_value_o,
  output logic [NUM_CPU-1:0]         irq_o,
  input  logic [NUM_CPU-1:0]         eoi_valid_i,
  input  logic [NUM_CPU*ACK_W-1:0]   eoi_data_i,
  input  logic [NUM_CPU-1:0]         clr_act_valid_i,
  input  logic [NUM_CPU*NUM_SGI-1:0] clr_act_data_i
);
  logic [ID_W-1:0]    send_id;
  logic               id_ok, send_ok;
  send_mode_e         send_mode;
  logic [NUM_CPU-1:0] tgt;

  assign send_id   = send_data_i[ID_W-1:0];
  assign id_ok     = ~|send_data_i[LIST_LSB-1:ID_W];
  assign send_ok   = send_valid_i && id_ok && (int'(send_src_i) < NUM_CPU);
  assign send_mode = send_mode_e'(send_data_i[MODE_LSB+1:MODE_LSB]);

  sgi_send_decode #(.NUM_CPU(NUM_CPU)) u_dec (
    .valid_i(send_ok),
    .src_i  (send_src_i),
    .mode_i (send_mode),
    .list_i (send_data_i[LIST_LSB+7:LIST_LSB]),
    .tgt_o  (tgt)
  );

  for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
    sgi_cpu_slot #(.NUM_CPU(NUM_CPU), .NUM_SGI(NUM_SGI)) u_slot (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .set_en_i   (tgt[c]),
      .set_src_i  (send_src_i),
      .set_id_i   (send_id),
      .ack_rd_i   (ack_rd_i[c]),
      .ack_value_o(ack_value_o[c*ACK_W +: ACK_W]),
      .irq_o      (irq_o[c]),
      .eoi_en_i   (eoi_valid_i[c]),
      .eoi_data_i (eoi_data_i[c*ACK_W +: ACK_W]),
      .clr_en_i   (clr_act_valid_i[c]),
      .clr_data_i (clr_act_data_i[c*NUM_SGI +: NUM_SGI])
    );
  end

  AST_OTHERS_SKIP_SELF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (send_valid_i && send_mode == MODE_OTHERS) |-> !((tgt >> send_src_i) & 1'b1)); // R2
  AST_SELF_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (send_ok && send_mode == MODE_SELF) |-> ($countones(tgt) == 1 && ((tgt >> send_src_i) & 1'b1))); // R3
  AST_BAD_ID_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (send_valid_i && !id_ok) |-> tgt == '0); // R1
endmodule

// File: tb/sgi_xbar_bench.sv
module sgi_xbar_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NC = 8;
  localparam int NS = 16;
  localparam int AW = 13;
  localparam logic [12:0] SPUR = 13'd1023;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              send_valid = 1'b0;
  logic [2:0]        send_src = '0;
  logic [25:0]       send_data = '0;
  logic [NC-1:0]     ack_rd = '0;
  logic [NC*AW-1:0]  ack_value;
  logic [NC-1:0]     irq;
  logic [NC-1:0]     eoi_valid = '0;
  logic [NC*AW-1:0]  eoi_data = '0;
  logic [NC-1:0]     clr_valid = '0;
  logic [NC*NS-1:0]  clr_data = '0;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  typedef struct {
    int          cpu;
    logic [12:0] val;
    string       tag;
  } exp_t;
  exp_t exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  sgi_xbar u_sgi_xbar (
    .clk_i          (clk),
    .rst_ni         (rst_n),
    .send_valid_i   (send_valid),
    .send_src_i     (send_src),
    .send_data_i    (send_data),
    .ack_rd_i       (ack_rd),
    .ack_value_o    (ack_value),
    .irq_o          (irq),
    .eoi_valid_i    (eoi_valid),
    .eoi_data_i     (eoi_data),
    .clr_act_valid_i(clr_valid),
    .clr_act_data_i (clr_data)
  );

  function automatic logic [12:0] av(int src, int id);
    return 13'((src << 10) | id);
  endfunction

  task automatic send_raw(input int src, input logic [25:0] d);
    @(negedge clk);
    send_valid = 1'b1; send_src = 3'(src); send_data = d;
    @(negedge clk);
    send_valid = 1'b0; send_data = '0;
  endtask

  task automatic send(input int src, input int mode, input int list, input int id);
    send_raw(src, {2'(mode), 8'(list), 12'h000, 4'(id)});
  endtask

  task automatic expect_ack(input int cpu, input logic [12:0] val, input string tag);
    exp_t e;
    e.cpu = cpu; e.val = val; e.tag = tag;
    exp_q.push_back(e);
  endtask

  task automatic expect_all_spur(input string tag);
    for (int c = 0; c < NC; c++) expect_ack(c, SPUR, tag);
  endtask

  // monitor: pops expectations, compares the port value and takes non-spurious ones
  task automatic drain();
    exp_t e;
    logic [12:0] got;
    while (exp_q.size() > 0) begin
      e = exp_q.pop_front();
      got = ack_value[e.cpu*AW +: AW];
      n_cmp++;
      if (got !== e.val) begin
        n_bad++;
        $display("FAIL %s cpu%0d ack: actual %h expected %h", e.tag, e.cpu, got, e.val);
      end
      n_cmp++;
      if (irq[e.cpu] !== (e.val != SPUR)) begin
        n_bad++;
        $display("FAIL R11 cpu%0d irq: actual %b expected %b", e.cpu, irq[e.cpu], e.val != SPUR);
      end
      if (e.val != SPUR) begin
        ack_rd[e.cpu] = 1'b1;
        @(negedge clk);
        ack_rd = '0;
      end
    end
  endtask

  task automatic eoi(input int cpu, input logic [12:0] v);
    @(negedge clk);
    eoi_valid[cpu] = 1'b1; eoi_data[cpu*AW +: AW] = v;
    @(negedge clk);
    eoi_valid = '0; eoi_data = '0;
  endtask

  task automatic clr(input int cpu, input logic [NS-1:0] m);
    @(negedge clk);
    clr_valid[cpu] = 1'b1; clr_data[cpu*NS +: NS] = m;
    @(negedge clk);
    clr_valid = '0; clr_data = '0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    expect_all_spur("R11 reset");
    drain();

    // R3: self only, one delivery
    send(1, 2, 8'hff, 1);
    expect_ack(1, av(1, 1), "R3 self");
    expect_all_spur("R6 single delivery");
    drain();
    eoi(1, av(1, 1));

    // R2: all except requester
    send(1, 1, 8'h00, 1);
    for (int c = 0; c < NC; c++) expect_ack(c, (c == 1) ? SPUR : av(1, 1), "R2 others");
    expect_all_spur("R6 single delivery");
    drain();
    for (int c = 0; c < NC; c++) if (c != 1) eoi(c, av(1, 1));

    // R1: list mode
    send(3, 0, 8'h0A, 5);
    expect_ack(1, av(3, 5), "R1 list");
    expect_ack(3, av(3, 5), "R1 list");
    expect_all_spur("R1 list non-target");
    drain();
    eoi(1, av(3, 5));
    eoi(3, av(3, 5));

    // R5 / R10: ordering and per-source pending
    send(2, 0, 8'h01, 7);
    send(5, 0, 8'h01, 3);
    send(1, 0, 8'h01, 3);
    expect_ack(0, av(1, 3), "R5 lowest id then src");
    expect_ack(0, av(5, 3), "R10 second source");
    expect_ack(0, av(2, 7), "R5 higher id last");
    expect_ack(0, SPUR, "R4 empty");
    drain();
    eoi(0, av(1, 3)); eoi(0, av(5, 3)); eoi(0, av(2, 7));

    // R7 / R8: active masking and completion matching
    send(0, 0, 8'h04, 4);
    expect_ack(2, av(0, 4), "R8 first");
    drain();
    send(0, 0, 8'h04, 4);
    expect_ack(2, SPUR, "R7 active masked");
    drain();
    eoi(2, av(1, 4));
    expect_ack(2, SPUR, "R8 wrong source ignored");
    drain();
    eoi(2, av(0, 4));
    expect_ack(2, av(0, 4), "R8 completed then shown");
    expect_ack(2, SPUR, "R8 drained");
    drain();
    eoi(2, av(0, 4));

    // R9 / R10: clear-active across sources
    send(6, 0, 8'h10, 9);
    expect_ack(4, av(6, 9), "R9 first");
    drain();
    send(6, 0, 8'h10, 9);
    send(3, 0, 8'h10, 9);
    expect_ack(4, av(3, 9), "R10 other source not masked");
    expect_ack(4, SPUR, "R7 both active");
    drain();
    clr(4, 16'h0200);
    expect_ack(4, av(6, 9), "R9 clear-active");
    drain();
    clr(4, 16'h0200);
    expect_ack(4, SPUR, "R9 all clear");
    drain();

    // R3 mode 3 and R1 out-of-range ID
    send(0, 3, 8'hff, 2);
    expect_all_spur("R3 mode none");
    drain();
    send_raw(0, {2'd0, 8'hff, 16'h0022});
    expect_all_spur("R1 bad id dropped");
    drain();

    finish_run();
  end
endmodule